// File: doc/BRIEF.md
# Two-Wire Write-Only Configuration Receiver

This block is a serial slave on a two-wire bus that only accepts writes. A bus master sends one fixed-length block write. The block checks the device address, skips the two protocol header bytes, and loads the payload bytes into a bank of eight 8-bit configuration registers. Each register has its own one-cycle update strobe, so downstream logic, such as the clock synthesizer that reads the spread-control bits of register 0, can react to a new value.

The bus lines are sampled with a faster system clock. Both lines pass through two-flop synchronizers, and the block finds clock edges, start conditions and stop conditions in the synchronized samples. The only thing the block drives is an open-drain pull-down enable, which it uses to acknowledge bytes. The block has no read path and never stretches the clock. After reset the registers hold parameterized defaults, so using the bus is optional.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset every register holds its default value (0xFF in each byte with default parameters), no update strobe is active and the pull-down is released.
- R2: A frame whose first byte, received MSB first, equals 0xD2 has that byte acknowledged: the pull-down is active while SCL is high during the ninth clock.
- R3: If the first byte of a frame differs from 0xD2, neither that byte nor any later byte of the frame is acknowledged, and no register changes.
- R4: Frame bytes 2 and 3 (the command and count bytes) are acknowledged, but their values change no register and raise no strobe.
- R5: Frame byte 4+k (k = 0..7) is shifted in MSB first. It is written into register k, which sits at bits [8k+7:8k] of the register output, on the SCL falling edge that ends its acknowledge clock. That write comes with a one-cycle pulse on strobe bit k.
- R6: Bytes after the eleventh byte of a frame are not acknowledged and do not change any register.
- R7: A stop condition or a repeated start that arrives in the middle of a byte discards the partial byte. After a repeated start, parsing begins again at the address byte.
- R8: At most one strobe bit is active in any cycle, and the register outputs change only in a cycle in which a strobe is active.
- R9: The pull-down enable changes only while SCL is low, and it is released in the cycle after a stop condition is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level as seen on the wired bus |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls the data line low for acknowledge |
| cfgRegs | output | 64 | Register bank; register k occupies bits [8k+7:8k] |
| cfgWrStb | output | 8 | One-cycle update strobe per register |

## Verification
Several frame shapes are driven into the block:
- A complete frame, with payload values such as 0x80 and 0x01 that would be garbled if the bit order or byte placement were wrong.
- A frame that stops after a few payload bytes. This separates per-byte commits from whole-frame commits.
- Address bytes that differ in the LSB or in the MSB, which shows that every address bit is compared.
- A header-only frame, which shows that the command and count bytes are skipped.
- A twelfth byte, which exercises the end of the frame.
- A stop and a repeated start arriving in the middle of a byte, which show that partial bytes are never committed and that parsing restarts at the address.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
package cfg_rx_pkg;
  // address + command + count bytes preceding the payload
  localparam int HDR_BYTES = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SKIP
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic clrBit;
    logic clrByte;
    logic incByte;
    logic commit;
  } dpCmd_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteFull;
    logic atAddr;
    logic addrMatch;
    logic pastEnd;
    logic isData;
  } dpStat_t;
endpackage

// File: rtl/cfg_rx_dp.sv
`timescale 1ns/1ps
module cfg_rx_dp
  import cfg_rx_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hD2,
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_INIT = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  dpCmd_t cmd,
  output dpStat_t stat,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  output logic [NUM_REGS-1:0] cfgWrStb
);
  localparam int FRAME_LEN = HDR_BYTES + NUM_REGS;
  localparam int IDX_W = $clog2(FRAME_LEN + 1);
  localparam int BIT_W = $clog2(BYTE_W + 1);

  // two-or-more flop synchronizers, idle bus level is high
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
    end
  end

  logic sclS, sdaS, sclQ, sdaQ;
  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  // shift register and bit counter
  logic [BYTE_W-1:0] shiftReg;
  logic [BIT_W-1:0] bitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt <= '0;
    end else if (cmd.clrBit) begin
      bitCnt <= '0;
    end else if (cmd.shift) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // frame byte index, saturating one past the last payload byte
  logic [IDX_W-1:0] byteIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (cmd.clrByte) begin
      byteIdx <= '0;
    end else if (cmd.incByte && byteIdx != IDX_W'(FRAME_LEN)) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_comb begin
    stat.sclRise = sclS & ~sclQ;
    stat.sclFall = ~sclS & sclQ;
    stat.startSeen = sclS & sclQ & sdaQ & ~sdaS;
    stat.stopSeen = sclS & sclQ & ~sdaQ & sdaS;
    stat.byteFull = (bitCnt == BIT_W'(BYTE_W));
    stat.atAddr = (byteIdx == '0);
    stat.addrMatch = (shiftReg == DEV_ADDR);
    stat.pastEnd = (byteIdx == IDX_W'(FRAME_LEN));
    stat.isData = (byteIdx >= IDX_W'(HDR_BYTES)) && (byteIdx < IDX_W'(FRAME_LEN));
  end

  // register bank, one slot per payload byte
  logic [NUM_REGS-1:0][BYTE_W-1:0] regQ;
  logic [NUM_REGS-1:0] stbQ;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = cmd.commit && (byteIdx == IDX_W'(HDR_BYTES + k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[k] <= REG_INIT[k*BYTE_W +: BYTE_W];
        stbQ[k] <= 1'b0;
      end else begin
        stbQ[k] <= hit;
        if (hit) regQ[k] <= shiftReg;
      end
    end
  end

  assign cfgRegs = regQ;
  assign cfgWrStb = stbQ;
endmodule

// File: rtl/cfg_rx_ctrl.sv
`timescale 1ns/1ps
module cfg_rx_ctrl
  import cfg_rx_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  dpStat_t stat,
  output dpCmd_t cmd,
  output logic sdaDriveLow
);
  rxState_e state, stateNext;
  logic ackQ, ackNext;

  always_comb begin
    stateNext = state;
    ackNext = ackQ;
    cmd = '0;
    if (stat.startSeen) begin
      stateNext = ST_RECV;
      cmd.clrBit = 1'b1;
      cmd.clrByte = 1'b1;
      ackNext = 1'b0;
    end else if (stat.stopSeen) begin
      stateNext = ST_IDLE;
      ackNext = 1'b0;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (stat.sclRise && !stat.byteFull) begin
            cmd.shift = 1'b1;
          end else if (stat.sclFall && stat.byteFull) begin
            if ((stat.atAddr && !stat.addrMatch) || stat.pastEnd) begin
              stateNext = ST_SKIP;
              cmd.clrBit = 1'b1;
            end else begin
              stateNext = ST_ACK;
              ackNext = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (stat.sclFall) begin
            ackNext = 1'b0;
            cmd.commit = stat.isData;
            cmd.incByte = 1'b1;
            cmd.clrBit = 1'b1;
            stateNext = ST_RECV;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ackQ <= 1'b0;
    end else begin
      state <= stateNext;
      ackQ <= ackNext;
    end
  end

  assign sdaDriveLow = ackQ;
endmodule

// File: rtl/cfg_serial_rx.sv
`timescale 1ns/1ps
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hD2,
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_INIT = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow,
  output logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  output logic [NUM_REGS-1:0] cfgWrStb
);
  dpCmd_t dpCmd;
  dpStat_t dpStat;
  logic busStop;

  cfg_rx_dp #(
    .NUM_REGS(NUM_REGS),
    .BYTE_W(BYTE_W),
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR(DEV_ADDR),
    .REG_INIT(REG_INIT)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .cmd(dpCmd),
    .stat(dpStat),
    .cfgRegs(cfgRegs),
    .cfgWrStb(cfgWrStb)
  );

  cfg_rx_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .stat(dpStat),
    .cmd(dpCmd),
    .sdaDriveLow(sdaDriveLow)
  );

  assign busStop = dpStat.stopSeen;
endmodule

// File: rtl/cfg_serial_rx_chk.sv
`timescale 1ns/1ps
module cfg_serial_rx_chk #(
  parameter int NUM_REGS = 8,
  parameter int BYTE_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaDriveLow,
  input logic busStop,
  input logic [NUM_REGS*BYTE_W-1:0] cfgRegs,
  input logic [NUM_REGS-1:0] cfgWrStb
);
  // R8
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfgWrStb));

  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrStb == '0) |-> $stable(cfgRegs));

  // R5
  stb_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|cfgWrStb) |-> $past(sdaDriveLow));

  // R9
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> !sdaDriveLow);
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(
  .NUM_REGS(NUM_REGS),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sclIn(sclIn),
  .sdaDriveLow(sdaDriveLow),
  .busStop(busStop),
  .cfgRegs(cfgRegs),
  .cfgWrStb(cfgWrStb)
);

// File: tb/sim_cfg_serial_rx.sv
`timescale 1ns/1ps
module sim_cfg_serial_rx;
  localparam int H = 16;
  localparam logic [63:0] INIT = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaDriveLow;
  logic [63:0] cfgRegs;
  logic [7:0] cfgWrStb;

  int checks = 0;
  int errors = 0;
  int stbCount = 0;
  bit done = 1'b0;
  logic [63:0] model;

  assign sdaBus = sdaM & ~sdaDriveLow;

  cfg_serial_rx u0 (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclM),
    .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow),
    .cfgRegs(cfgRegs),
    .cfgWrStb(cfgWrStb)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) stbCount <= 0;
    else stbCount <= stbCount + $countones(cfgWrStb);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (H) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; halfWait();
    sclM = 1'b1; halfWait();
    sdaM = 1'b0; halfWait();
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; halfWait();
    sclM = 1'b1; halfWait();
    sdaM = 1'b1; halfWait();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; halfWait();
      sclM = 1'b1; halfWait();
      sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; halfWait();
    sclM = 1'b1;
    repeat (H/2) @(negedge clk);
    acked = (sdaBus == 1'b0);
    repeat (H/2) @(negedge clk);
    sclM = 1'b0;
  endtask

  task automatic writeFrame(input logic [7:0] addr, input logic [63:0] data,
                            input int nData, output int ackCnt);
    bit a;
    ackCnt = 0;
    startCond();
    sendByte(addr, a); ackCnt += int'(a);
    sendByte(8'hA5, a); ackCnt += int'(a);
    sendByte(8'h08, a); ackCnt += int'(a);
    for (int k = 0; k < nData; k++) begin
      sendByte(data[8*k +: 8], a); ackCnt += int'(a);
    end
    stopCond();
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(cfgRegs == INIT, "R1", "register defaults", cfgRegs, INIT);
    chk(cfgWrStb == '0, "R1", "strobes idle", 64'(cfgWrStb), 64'h0);
    chk(sdaDriveLow == 1'b0, "R1", "pull-down released", 64'(sdaDriveLow), 64'h0);
  endtask

  task automatic testFullFrame();
    int acks, s0;
    logic [63:0] d = 64'h8001_C33C_5AA5_7E18;
    s0 = stbCount;
    writeFrame(8'hD2, d, 8, acks);
    model = d;
    chk(acks == 11, "R2", "acks on full frame", 64'(acks), 64'd11);
    chk(cfgRegs == model, "R5", "payload placement", cfgRegs, model);
    chk(stbCount - s0 == 8, "R5", "strobe count", 64'(stbCount - s0), 64'd8);
    chk(sdaDriveLow == 1'b0, "R9", "released after stop", 64'(sdaDriveLow), 64'h0);
  endtask

  task automatic testHeaderOnly();
    bit a;
    int s0;
    s0 = stbCount;
    startCond();
    sendByte(8'hD2, a);
    chk(a, "R2", "address ack", 64'(a), 64'h1);
    sendByte(8'hFF, a);
    chk(a, "R4", "command ack", 64'(a), 64'h1);
    sendByte(8'h00, a);
    chk(a, "R4", "count ack", 64'(a), 64'h1);
    repeat (8) @(negedge clk);
    chk(cfgRegs == model, "R4", "header leaves registers", cfgRegs, model);
    chk(stbCount == s0, "R4", "header raises no strobe", 64'(stbCount - s0), 64'h0);
    stopCond();
    chk(cfgRegs == model, "R4", "registers after stop", cfgRegs, model);
  endtask

  task automatic testBadAddr(input logic [7:0] addr);
    int acks, s0;
    s0 = stbCount;
    writeFrame(addr, 64'h1122_3344_5566_7788, 8, acks);
    chk(acks == 0, "R3", "no ack on foreign frame", 64'(acks), 64'h0);
    chk(cfgRegs == model, "R3", "foreign frame ignored", cfgRegs, model);
    chk(stbCount == s0, "R3", "no strobe on foreign frame", 64'(stbCount - s0), 64'h0);
  endtask

  task automatic testOverrun();
    bit a;
    int s0;
    logic [63:0] d = 64'h0F1E_2D3C_4B5A_6978;
    s0 = stbCount;
    startCond();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h08, a);
    for (int k = 0; k < 8; k++) sendByte(d[8*k +: 8], a);
    model = d;
    sendByte(8'h00, a);
    chk(!a, "R6", "twelfth byte not acked", 64'(a), 64'h0);
    stopCond();
    chk(cfgRegs == model, "R6", "twelfth byte ignored", cfgRegs, model);
    chk(stbCount - s0 == 8, "R6", "only eight strobes", 64'(stbCount - s0), 64'd8);
  endtask

  task automatic testStopMidByte();
    bit a;
    startCond();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h3C, a);
    model[7:0] = 8'h3C;
    sendBits(8'h00, 4);
    stopCond();
    chk(cfgRegs == model, "R7", "stop discards partial byte", cfgRegs, model);
  endtask

  task automatic testRestartMidByte();
    bit a;
    int acks;
    startCond();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendBits(8'h00, 5);
    startCond();
    sendByte(8'hD2, a);
    chk(a, "R7", "address acked after repeated start", 64'(a), 64'h1);
    sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h96, a);
    model[7:0] = 8'h96;
    stopCond();
    chk(cfgRegs == model, "R7", "restart reparses frame", cfgRegs, model);
    writeFrame(8'hD2, 64'hAAAA_AAAA_AAAA_6655, 2, acks);
    model[15:0] = 16'h6655;
    chk(acks == 5, "R5", "short frame acks", 64'(acks), 64'd5);
    chk(cfgRegs == model, "R5", "short frame commits per byte", cfgRegs, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model = INIT;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testHeaderOnly();
    testFullFrame();
    testBadAddr(8'hD3);
    testBadAddr(8'h52);
    testOverrun();
    testStopMidByte();
    testRestartMidByte();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule